// File: doc/BRIEF.md
# Buzzer Pair and Programmable Tone Output Stage

This block drives three output pins of a general-purpose port. Two of them form a tone pair: the same audio source can appear on both pins in opposite phase (for a piezo element driven differentially), on one pin only, or on neither. The third pin carries a square wave from a reloading 8-bit up-counter and its divider flip-flop. The pin data-register bits do not carry data here. They are read as an encoding that picks which signal each pin drives.

The counter advances on each internal clock enable while the run control is high. It starts from a preload value N. When it reaches its top value, the next enable reloads N and toggles the divider flip-flop. The square wave therefore has a period of 2×(256−N) enables. All three pin levels are registered, so each one follows its inputs one clock later.

Top module: `tone_port_stage`

## Requirements
- R1: While reset is high at a clock edge, all three pins go low, the divider flip-flop clears to 0 and the counter loads the current preload value.
- R2: With sel_a_i=0 and sel_b_i=0, one clock later tone_a_o equals tone_i and tone_b_o equals the inverse of tone_i.
- R3: With sel_a_i=0 and sel_b_i=1, one clock later tone_a_o equals tone_i and tone_b_o is 0.
- R4: With sel_a_i=1, one clock later tone_a_o and tone_b_o are both 0, whatever sel_b_i and tone_i are.
- R5: With run_i=1, the counter steps up by one on each enable. On an enable that finds it at 255, it reloads N and the divider flips. With enables on every cycle, each level of the divider lasts 256−N cycles (for example 6 cycles for N=250 and 1 cycle for N=255).
- R6: With sel_f_i=0, freq_o equals the divider flip-flop value of the previous clock.
- R7: With sel_f_i=1, freq_o is 0 one clock later, whether or not the counter runs.
- R8: With run_i=0, the counter and the divider hold. With sel_f_i=0, freq_o therefore keeps its last value.
- R9: A change of preload_i while the counter runs does not alter the count in progress. The new value is used from the next reload on.
- R10: A cycle with tick_i=0 leaves the counter and the divider unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Internal clock enable for the counter |
| run_i | input | 1 | Counter run control |
| preload_i | input | CNT_W | Reload value N |
| sel_a_i | input | 1 | Data bit of the first pair pin (mute select) |
| sel_b_i | input | 1 | Data bit of the second pair pin (single-ended select) |
| sel_f_i | input | 1 | Data bit of the divider pin (mute select) |
| tone_i | input | 1 | Buzzer source signal |
| tone_a_o | output | 1 | First pin of the tone pair |
| tone_b_o | output | 1 | Second pin of the tone pair |
| freq_o | output | 1 | Divider output pin |

## Verification
A counter reload and a change to the preload can land in the same cycle, or close together. The same applies to a reload and a change to the mute or run control. The random phase keeps N between 240 and 255 so that reloads come often. It changes preload, run, enable and every select bit at random on those same cycles. A bench model, written from the requirements, predicts the count and the divider and so settles which preload value each reload should pick up. Directed runs then measure the divider's half-periods across a preload change: the first must still reflect the old N and the next the new one.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    PAIR_COMP   = 2'd0,
    PAIR_SINGLE = 2'd1,
    PAIR_MUTE   = 2'd2
  } pair_mode_e;

  function automatic pair_mode_e pair_decode(input logic sel_a, input logic sel_b);
    if (sel_a)      return PAIR_MUTE;
    else if (sel_b) return PAIR_SINGLE;
    else            return PAIR_COMP;
  endfunction
endpackage

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = run & tick;
  assign wrap = step & (cnt_q == TOP);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= preload;
    end else if (step) begin
      if (cnt_q == TOP) cnt_q <= preload;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/divider_ff.sv
module divider_ff (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic q
);
  logic q_r;
  assign q = q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= 1'b0;
    else if (flip) q_r <= ~q_r;
  end
endmodule

// File: rtl/pin_select.sv
module pin_select
  import tone_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic                sel_a,
  input  logic                sel_b,
  input  logic                sel_f,
  input  logic                tone,
  input  logic                div,
  output logic [NUM_PINS-1:0] pin_next
);
  pair_mode_e mode;

  always_comb begin
    mode     = pair_decode(sel_a, sel_b);
    pin_next = '0;
    unique case (mode)
      PAIR_COMP: begin
        pin_next[0] = tone;
        pin_next[1] = ~tone;
      end
      PAIR_SINGLE: begin
        pin_next[0] = tone;
        pin_next[1] = 1'b0;
      end
      default: begin
        pin_next[0] = 1'b0;
        pin_next[1] = 1'b0;
      end
    endcase
    pin_next[NUM_PINS-1] = sel_f ? 1'b0 : div;
  end
endmodule

// File: rtl/tone_port_stage.sv
module tone_port_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  input  logic             sel_f_i,
  input  logic             tone_i,
  output logic             tone_a_o,
  output logic             tone_b_o,
  output logic             freq_o
);
  localparam int NUM_PINS = 3;

  logic [CNT_W-1:0]    cnt_w;
  logic                wrap_w;
  logic                div_w;
  logic [NUM_PINS-1:0] pin_next;
  logic [NUM_PINS-1:0] pin_q;

  reload_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .run     (run_i),
    .preload (preload_i),
    .cnt     (cnt_w),
    .wrap    (wrap_w)
  );

  divider_ff u_div (
    .clk  (clk),
    .rst  (rst),
    .flip (wrap_w),
    .q    (div_w)
  );

  pin_select #(.NUM_PINS(NUM_PINS)) u_sel (
    .sel_a    (sel_a_i),
    .sel_b    (sel_b_i),
    .sel_f    (sel_f_i),
    .tone     (tone_i),
    .div      (div_w),
    .pin_next (pin_next)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_reg
    always_ff @(posedge clk) begin
      if (rst) pin_q[g] <= 1'b0;
      else     pin_q[g] <= pin_next[g];
    end
  end

  assign tone_a_o = pin_q[0];
  assign tone_b_o = pin_q[1];
  assign freq_o   = pin_q[NUM_PINS-1];
endmodule

// File: rtl/tone_port_chk.sv
module tone_port_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             run_i,
  input logic [CNT_W-1:0] preload_i,
  input logic             sel_a_i,
  input logic             sel_b_i,
  input logic             sel_f_i,
  input logic             tone_i,
  input logic             tone_a_o,
  input logic             tone_b_o,
  input logic             freq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             div
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_RESET_PINS: assert property (@(posedge clk) rst |=> (!tone_a_o && !tone_b_o && !freq_o && !div)); // R1
  AST_PAIR_COMP: assert property (@(posedge clk) disable iff (rst)
    (!sel_a_i && !sel_b_i) |=> (tone_a_o == $past(tone_i) && tone_b_o == !$past(tone_i))); // R2
  AST_PAIR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!sel_a_i && sel_b_i) |=> (tone_a_o == $past(tone_i) && !tone_b_o)); // R3
  AST_PAIR_MUTE: assert property (@(posedge clk) disable iff (rst)
    sel_a_i |=> (!tone_a_o && !tone_b_o)); // R4
  AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && cnt == TOP) |=> (div != $past(div))); // R5
  AST_FREQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !sel_f_i |=> (freq_o == $past(div))); // R6
  AST_FREQ_MUTE: assert property (@(posedge clk) disable iff (rst)
    sel_f_i |=> !freq_o); // R7
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> ($stable(cnt) && $stable(div))); // R8
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && cnt == TOP) |=> (cnt == $past(preload_i))); // R9
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(cnt) && $stable(div))); // R10
endmodule

bind tone_port_stage tone_port_chk #(.CNT_W(CNT_W)) u_tone_port_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_i    (tick_i),
  .run_i     (run_i),
  .preload_i (preload_i),
  .sel_a_i   (sel_a_i),
  .sel_b_i   (sel_b_i),
  .sel_f_i   (sel_f_i),
  .tone_i    (tone_i),
  .tone_a_o  (tone_a_o),
  .tone_b_o  (tone_b_o),
  .freq_o    (freq_o),
  .cnt       (cnt_w),
  .div       (div_w)
);

// File: tb/test_tone_port_stage.sv
module test_tone_port_stage;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic run_i = 1'b0;
  logic [CNT_W-1:0] preload_i = '0;
  logic sel_a_i = 1'b0;
  logic sel_b_i = 1'b0;
  logic sel_f_i = 1'b0;
  logic tone_i = 1'b0;
  logic tone_a_o, tone_b_o, freq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0] m_cnt = '0;
  logic m_div = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_port_stage #(.CNT_W(CNT_W)) i_tone_port_stage (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i), .preload_i(preload_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .sel_f_i(sel_f_i), .tone_i(tone_i),
    .tone_a_o(tone_a_o), .tone_b_o(tone_b_o), .freq_o(freq_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_pair_a(input logic sa, input logic t);
    return sa ? 1'b0 : t;
  endfunction

  function automatic logic exp_pair_b(input logic sa, input logic sb, input logic t);
    return (sa || sb) ? 1'b0 : ~t;
  endfunction

  // One clock: predict at the edge from the pre-edge model, compare 1 time unit later
  task automatic step();
    logic e0, e1, e3;
    string tp, tf;
    @(posedge clk);
    if (rst) begin
      e0 = 1'b0; e1 = 1'b0; e3 = 1'b0;
      tp = "R1 pair"; tf = "R1 freq";
      m_cnt = preload_i; m_div = 1'b0;
    end else begin
      e0 = exp_pair_a(sel_a_i, tone_i);
      e1 = exp_pair_b(sel_a_i, sel_b_i, tone_i);
      e3 = sel_f_i ? 1'b0 : m_div;
      tp = sel_a_i ? "R4 pair" : (sel_b_i ? "R3 pair" : "R2 pair");
      tf = sel_f_i ? "R7 freq" : (run_i ? "R6 freq" : "R8 freq");
      if (run_i && tick_i) begin
        if (m_cnt == {CNT_W{1'b1}}) begin
          m_cnt = preload_i;
          m_div = ~m_div;
        end else begin
          m_cnt = m_cnt + 1'b1;
        end
      end
    end
    #1;
    chk({tp, " pin a"}, tone_a_o, e0);
    chk({tp, " pin b"}, tone_b_o, e1);
    chk(tf, freq_o, e3);
  endtask

  // Steps until freq_o changes; returns the number of steps taken
  task automatic until_edge(output int n);
    logic last;
    last = freq_o;
    n = 0;
    do begin
      step();
      n++;
    end while (freq_o == last && n < 600);
  endtask

  task automatic do_reset(input logic [CNT_W-1:0] n);
    preload_i = n;
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic held;
    void'($urandom(32'd4242));
    #1;

    // R1: reset state
    do_reset(8'd250);
    chk("R1 reset pin a", tone_a_o, 1'b0);
    chk("R1 reset pin b", tone_b_o, 1'b0);
    chk("R1 reset freq", freq_o, 1'b0);

    // R2 R3 R4: directed select patterns
    for (int i = 0; i < 8; i++) begin
      sel_a_i = i[2]; sel_b_i = i[1]; tone_i = i[0];
      step();
    end

    // R5: half-periods for N=250 and N=255
    tick_i = 1'b1; run_i = 1'b1; sel_f_i = 1'b0;
    do_reset(8'd250);
    until_edge(n);
    until_edge(n);
    chk_int("R5 half period N=250", n, 6);
    do_reset(8'd255);
    until_edge(n);
    until_edge(n);
    chk_int("R5 half period N=255", n, 1);

    // R9: preload change mid-count applies from the next reload
    do_reset(8'd250);
    until_edge(n);
    preload_i = 8'd252;
    until_edge(n);
    chk_int("R9 count in progress keeps old N", n, 6);
    until_edge(n);
    chk_int("R9 new N after reload", n, 4);

    // R10: no enables, divider must not move
    tick_i = 1'b0;
    held = freq_o;
    repeat (20) step();
    chk("R10 freq held without tick", freq_o, held);
    tick_i = 1'b1;

    // R8: stopped counter holds its last divider level
    repeat (3) step();
    run_i = 1'b0;
    step();
    held = freq_o;
    repeat (20) step();
    chk("R8 freq held while stopped", freq_o, held);

    // R7: mute while running
    run_i = 1'b1; sel_f_i = 1'b1;
    repeat (20) step();
    chk("R7 freq muted", freq_o, 1'b0);
    sel_f_i = 1'b0;

    // Random phase: all controls move, reloads frequent
    do_reset(8'd245);
    for (int i = 0; i < 4000; i++) begin
      tick_i = ($urandom_range(3, 0) != 0);
      run_i = ($urandom_range(9, 0) != 0);
      tone_i = $urandom_range(1, 0) != 0;
      if ($urandom_range(7, 0) == 0) sel_a_i = $urandom_range(1, 0) != 0;
      if ($urandom_range(7, 0) == 0) sel_b_i = $urandom_range(1, 0) != 0;
      if ($urandom_range(15, 0) == 0) sel_f_i = $urandom_range(1, 0) != 0;
      if ($urandom_range(9, 0) == 0) preload_i = CNT_W'($urandom_range(255, 240));
      step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule